// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Generator

This block drives the processor reset of a chip. Three sources assert reset. The first is power-on, modelled by the asynchronous system reset. The second is a digital flag from an external supply-low comparator. The third is a watchdog that expires when software stops restarting it. Whichever source fires, reset is stretched by one fixed time-out after that source goes quiet. The same reset state drives an active-high output and an active-low output.

All intervals are counted in ticks of a free-running timebase, one tick per scaled millisecond. A 2-bit select picks one of three watchdog periods, and its fourth code switches the watchdog off. The watchdog restarts when the kick input sees a pulse at least a minimum number of system clocks wide; shorter pulses have no effect. A change of the select also restarts the count. During reset the watchdog count is held at zero.

Top module: `sup_rst_gen`

## Requirements
- R1: When rst_ni is low, rst_o is 1. After rst_ni rises, rst_o stays 1 until RST_TICKS ticks have been counted, and then falls to 0.
- R2: rst_no is always the inverse of rst_o.
- R3: wd_sel_i selects the watchdog period: 2'b00 gives WD_TICKS_00, 2'b01 gives WD_TICKS_01 and 2'b10 gives WD_TICKS_10 ticks. When no qualified kick arrives, reset asserts on the period-th tick after the last restart.
- R4: wd_sel_i = 2'b11 turns the watchdog off, and the watchdog then never asserts reset. This code is also the value the select register takes at reset.
- R5: A kick pulse that stays high for at least KICK_MIN_CYC clocks restarts the watchdog. It is taken at its falling edge, after a two-flop synchronizer.
- R6: A kick pulse that stays high for fewer than KICK_MIN_CYC clocks is ignored, and the watchdog expires as if no kick had arrived.
- R7: While supply_low_i is 1, rst_o is 1 within 3 clocks and stays 1. After the flag clears, rst_o stays 1 for a further RST_TICKS ticks.
- R8: A watchdog expiry asserts rst_o on the next clock and holds it for RST_TICKS ticks.
- R9: While reset is active, the watchdog count is held at zero and kicks are ignored. After reset releases, the next expiry needs a full period.
- R10: Any change of wd_sel_i restarts the watchdog count, so an interval never mixes the old period with the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-clock strobe from the scaled timebase |
| supply_low_i | input | 1 | Supply-low comparator flag, active high, asynchronous |
| kick_i | input | 1 | Watchdog restart input, asynchronous |
| wd_sel_i | input | 2 | Watchdog period select (00, 01, 10 = periods, 11 = off) |
| rst_o | output | 1 | Reset, active high |
| rst_no | output | 1 | Reset, active low |

## Verification
Each result has its own latency. The supply flag reaches rst_o three clock edges after it changes: two for the synchronizer and one for loading the stretch counter. A kick takes effect about three clocks after its falling edge. A watchdog expiry reaches rst_o one clock after the period-th tick. A stretch or period of N ticks lasts between (N-1) and N tick intervals, depending on the tick phase. The bench therefore counts clocks from each stimulus to the edge on rst_o and accepts a window one tick interval wide, plus the fixed synchronizer and register delay. Every sample is taken on the falling clock edge.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sup_kick_qual.sv
module sup_kick_qual #(
  parameter int unsigned MIN_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

  logic [CW-1:0] wid_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wid_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_i;
      if (lvl_i) begin
        if (wid_q != SAT) wid_q <= wid_q + 1'b1;
      end else begin
        wid_q <= '0;
      end
    end
  end

  // accept on falling edge once the high time reached the minimum
  assign pulse_o = lvl_q & ~lvl_i & (wid_q == SAT);
endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
  import sup_rst_pkg::*;
#(
  parameter int unsigned P00 = 1400,
  parameter int unsigned P01 = 600,
  parameter int unsigned P10 = 200,
  parameter int unsigned CW  = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          kick_i,
  input  logic [1:0]    sel_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, lim;
  logic [1:0]    sel_q;
  logic          restart;

  always_comb begin
    case (wd_sel_e'(sel_i))
      WD_LONG:  lim = CW'(P00 - 1);
      WD_MID:   lim = CW'(P01 - 1);
      WD_SHORT: lim = CW'(P10 - 1);
      default:  lim = '0;
    endcase
  end

  assign restart  = hold_i | kick_i | (sel_i != sel_q) | (sel_i == WD_OFF);
  assign expire_o = ~restart & tick_i & (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= WD_OFF;
    end else begin
      sel_q <= sel_i;
      if (restart || expire_o) cnt_q <= '0;
      else if (tick_i)         cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch #(
  parameter int unsigned RST_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic trig_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_TICKS);

  logic [CW-1:0] cnt_q;

  // power-on loads the full stretch; any trigger reloads it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= LOAD;
    else if (trig_i)               cnt_q <= LOAD;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
  parameter int unsigned RST_TICKS    = 200,
  parameter int unsigned WD_TICKS_00  = 1400,
  parameter int unsigned WD_TICKS_01  = 600,
  parameter int unsigned WD_TICKS_10  = 200,
  parameter int unsigned KICK_MIN_CYC = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       supply_low_i,
  input  logic       kick_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o,
  output logic       rst_no
);
  localparam int unsigned WD_MAX = sup_rst_pkg::max3(WD_TICKS_00, WD_TICKS_01, WD_TICKS_10);
  localparam int unsigned WD_W   = $clog2(WD_MAX + 1);

  logic            sup_low_s, kick_s, kick_ok, wd_exp, rst_act;
  logic [WD_W-1:0] wd_cnt;

  sup_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({supply_low_i, kick_i}),
    .q_o   ({sup_low_s, kick_s})
  );

  sup_kick_qual #(.MIN_CYC(KICK_MIN_CYC)) u_kick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (kick_s),
    .pulse_o(kick_ok)
  );

  sup_wd_timer #(
    .P00(WD_TICKS_00), .P01(WD_TICKS_01), .P10(WD_TICKS_10), .CW(WD_W)
  ) u_wd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .hold_i  (rst_act),
    .kick_i  (kick_ok),
    .sel_i   (wd_sel_i),
    .expire_o(wd_exp),
    .cnt_o   (wd_cnt)
  );

  sup_rst_stretch #(.RST_TICKS(RST_TICKS)) u_str (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .trig_i  (sup_low_s | wd_exp),
    .active_o(rst_act)
  );

  assign rst_o  = rst_act;
  assign rst_no = ~rst_act;
endmodule

// File: rtl/sup_rst_gen_chk.sv
module sup_rst_gen_chk #(
  parameter int unsigned CW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rst_o,
  input logic          rst_no,
  input logic          sup_low_s,
  input logic          wd_exp,
  input logic [CW-1:0] wd_cnt,
  input logic [1:0]    wd_sel_i
);
  // R2
  polarity_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o != rst_no);

  // R7
  supply_low_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sup_low_s |=> rst_o);

  // R8
  expire_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_exp |=> rst_o);

  // R9
  hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |=> (wd_cnt == '0));

  // R4
  off_no_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i == 2'b11) |-> !wd_exp);

  // R10
  sel_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_sel_i != $past(wd_sel_i)) |=> (wd_cnt == '0));
endmodule

bind sup_rst_gen sup_rst_gen_chk #(.CW(WD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rst_o    (rst_o),
  .rst_no   (rst_no),
  .sup_low_s(sup_low_s),
  .wd_exp   (wd_exp),
  .wd_cnt   (wd_cnt),
  .wd_sel_i (wd_sel_i)
);

// File: tb/sim_sup_rst_gen.sv
`timescale 1ns/1ps
module sim_sup_rst_gen;
  localparam int RST_T = 8;
  localparam int P00   = 48;
  localparam int P01   = 32;
  localparam int P10   = 16;
  localparam int KMIN  = 20;
  localparam int TP    = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       supply_low = 1'b0;
  logic       kick = 1'b0;
  logic [1:0] sel = 2'b11;
  logic       rst_o, rst_no;
  int         tdiv = 0;
  int         nvec = 0;
  int         nbad = 0;
  int         r2_bad = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= (tdiv == TP - 1) ? 0 : tdiv + 1;
    tick <= (tdiv == TP - 1);
  end

  sup_rst_gen #(
    .RST_TICKS(RST_T), .WD_TICKS_00(P00), .WD_TICKS_01(P01),
    .WD_TICKS_10(P10), .KICK_MIN_CYC(KMIN)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .supply_low_i(supply_low),
    .kick_i(kick), .wd_sel_i(sel), .rst_o(rst_o), .rst_no(rst_no)
  );

  always @(negedge clk) if (rst_o == rst_no) r2_bad++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic win(input string req, input int n, input int lo, input int hi);
    chk(n >= lo && n <= hi, req, n, lo);
  endtask

  task automatic measure(input logic lvl, input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (rst_o == lvl) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic restart_sel(input logic [1:0] code);
    sel = 2'b11;
    repeat (2) @(negedge clk);
    sel = code;
  endtask

  task automatic t_por();
    int n;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    chk(rst_o == 1'b1, "R1 reset state", int'(rst_o), 1);
    chk(rst_no == 1'b0, "R2 reset state", int'(rst_no), 0);
    measure(1'b0, RST_T * TP + 10, n);
    win("R1 stretch", n, (RST_T - 1) * TP, RST_T * TP + 2);
  endtask

  task automatic t_off();
    int hi = 0;
    sel = 2'b11;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rst_o) hi++;
    end
    chk(hi == 0, "R4 off", hi, 0);
  endtask

  task automatic t_expire(input logic [1:0] code, input int p, input bit full);
    int n;
    restart_sel(code);
    measure(1'b1, p * TP + 20, n);
    win("R3 period", n, (p - 1) * TP, p * TP + 4);
    measure(1'b0, RST_T * TP + 10, n);
    if (full) begin
      win("R8 stretch", n, (RST_T - 1) * TP, RST_T * TP + 2);
      measure(1'b1, p * TP + 20, n);
      win("R9 full period", n, (p - 1) * TP, p * TP + 4);
      measure(1'b0, RST_T * TP + 10, n);
    end
  endtask

  task automatic kick_train(input int width, input int gap, input int maxc, output int first);
    int c = 0;
    first = -1;
    while (c < maxc && first < 0) begin
      for (int i = 0; i < gap + width && first < 0; i++) begin
        kick = (i >= gap);
        @(negedge clk);
        c++;
        if (rst_o) first = c;
      end
    end
    kick = 1'b0;
  endtask

  task automatic t_kick_ok();
    int f;
    restart_sel(2'b10);
    kick_train(KMIN, 25, 400, f);
    chk(f == -1, "R5 min width kick", f, -1);
  endtask

  task automatic t_kick_short();
    int f, n;
    restart_sel(2'b10);
    kick_train(KMIN - 1, 25, P10 * TP + 30, f);
    win("R6 short kick", f, (P10 - 1) * TP, P10 * TP + 4);
    measure(1'b0, RST_T * TP + 10, n);
  endtask

  task automatic t_sel_change();
    int n, hi = 0;
    restart_sel(2'b00);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (rst_o) hi++;
    end
    chk(hi == 0, "R10 before change", hi, 0);
    sel = 2'b01;
    measure(1'b1, P01 * TP + 20, n);
    win("R10 restart", n, (P01 - 1) * TP, P01 * TP + 4);
    measure(1'b0, RST_T * TP + 10, n);
  endtask

  task automatic t_supply();
    int n, lo = 0;
    sel = 2'b11;
    @(negedge clk);
    supply_low = 1'b1;
    repeat (3) @(negedge clk);
    chk(rst_o == 1'b1, "R7 assert", int'(rst_o), 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!rst_o) lo++;
    end
    chk(lo == 0, "R7 held", lo, 0);
    supply_low = 1'b0;
    measure(1'b0, RST_T * TP + 20, n);
    win("R7 stretch", n, (RST_T - 1) * TP + 2, RST_T * TP + 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog timeout act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    t_por();
    t_off();
    t_expire(2'b10, P10, 1'b1);
    t_expire(2'b00, P00, 1'b0);
    t_kick_ok();
    t_kick_short();
    t_sel_change();
    t_supply();
    chk(r2_bad == 0, "R2 polarity", r2_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule